// File: doc/BRIEF.md
# I2C Master Start Reservation Controller

This block decides what happens when software asks to become I2C bus master. It passes the raw SDA and SCL levels through a two-flop synchronizer and watches them for start and stop conditions. From these it keeps a bus-busy flag.

When a start request finds the bus free, the block drives a start condition at once. It pulls SDA low, holds it for a programmed count, then pulls SCL low and raises its master-status output. When the request finds the bus busy, the block does not drive the bus. It records a pending reservation instead, and launches the start by itself on the next detected stop.

A configuration bit turns the reservation behaviour off. With that bit set, a request on a busy bus is simply dropped. A write port holds the address byte for the coming transfer. A write made while a reservation is still waiting for its stop is discarded. A status-ready output tells software when the master-status output has settled after a request.

Byte shifting, acknowledge handling and arbitration itself live elsewhere; an arbitration-loss pulse arrives as an input.

Top module: `i2c_start_resv`

## Requirements
- R1: After reset: `sda_drive_low`, `scl_drive_low`, `master_st`, `resv_pend`, `bus_busy`, `stop_det` and `addr_valid` are 0, and `status_ready` is 1.
- R2: A falling SDA while SCL is high is a start and sets `bus_busy`. A rising SDA while SCL is high is a stop. An input change made between clock edges shows as a one-cycle `stop_det` pulse after the second following rising edge, and `bus_busy` clears on the edge that ends the pulse.
- R3: `stop_irq` equals `stop_det` while `stop_irq_en` is 1, and stays 0 while `stop_irq_en` is 0.
- R4: A `start_req` on a free bus raises `sda_drive_low` on the sampling edge. SDA is then held low alone for `cfg_hi_cnt`+1 cycles. After that, `scl_drive_low` and `master_st` rise together.
- R5: A `start_req` on a busy bus with `cfg_resv_off`=0 sets `resv_pend` on the sampling edge. Neither line is driven and `master_st` stays 0.
- R6: With `cfg_resv_off`=1, a `start_req` on a busy bus is dropped. `resv_pend` stays 0, and the following stop launches no start.
- R7: When `resv_pend` is 1 and `stop_det` pulses, `sda_drive_low` rises and `resv_pend` clears on the edge that ends the pulse. The R4 sequence then follows.
- R8: A `tx_wr` while `resv_pend` is 1 is ignored, and `addr_valid` keeps its value. A `tx_wr` at any other time loads `tx_data` into `addr_out` and sets `addr_valid` on the sampling edge.
- R9: `bus_release` clears `resv_pend`, `master_st`, `addr_valid` and both line drives on the sampling edge.
- R10: `arb_lost` returns a master, or a device still holding SDA, to idle. Both line drives, `master_st` and `addr_valid` clear on the sampling edge.
- R11: After each `start_req`, `status_ready` is 0 for exactly `cfg_lo_cnt`+`cfg_hi_cnt`+4+2×`cfg_fall_cnt` cycles and then returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Operation clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| start_req | input | 1 | One-cycle request to become master |
| bus_release | input | 1 | One-cycle command to let go of the bus and drop any reservation |
| arb_lost | input | 1 | One-cycle arbitration-loss indication |
| cfg_resv_off | input | 1 | 1 disables reservation on a busy bus |
| stop_irq_en | input | 1 | Enables the stop interrupt output |
| cfg_hi_cnt | input | CNT_W | High-width setting, also the start hold count |
| cfg_lo_cnt | input | CNT_W | Low-width setting |
| cfg_fall_cnt | input | CNT_W | Line fall time in clocks |
| tx_wr | input | 1 | Transmit-register write strobe |
| tx_data | input | DATA_W | Transmit-register write data |
| sda_drive_low | output | 1 | Pull SDA low |
| scl_drive_low | output | 1 | Pull SCL low |
| master_st | output | 1 | Device holds the bus as master |
| resv_pend | output | 1 | A start is reserved for the next stop |
| bus_busy | output | 1 | A start was seen more recently than a stop |
| stop_det | output | 1 | One-cycle stop detection pulse |
| stop_irq | output | 1 | Stop interrupt |
| status_ready | output | 1 | Master status has settled since the last request |
| addr_out | output | DATA_W | Held address byte |
| addr_valid | output | 1 | `addr_out` holds an accepted write |

## Verification
The assertions assume that `start_req`, `bus_release`, `arb_lost` and `tx_wr` are single-cycle pulses. They also assume that SCL stays high whenever another master moves SDA, so that every SDA edge is a start or a stop. The stimulus models the bus as a wired-AND of the bench's own line levels and the block's drive outputs. It changes those levels only on falling clock edges and keeps SCL high throughout, so the only SCL activity comes from the block itself.

// File: rtl/i2c_resv_pkg.sv
package i2c_resv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2
  } mst_state_t;

  // Cycles software waits after a request before master status is meaningful
  function automatic int unsigned settle_cycles(input int unsigned lo_w,
                                                input int unsigned hi_w,
                                                input int unsigned fall_w);
    return lo_w + hi_w + 4 + 2 * fall_w;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_in,
  output logic [LINES-1:0] sync_out
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw_in[g]};
    end
    assign sync_out[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic scl_s,
  output logic start_det,
  output logic stop_det,
  output logic bus_busy
);

  logic sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_prev <= 1'b1;
    else        sda_prev <= sda_s;
  end

  assign start_det = scl_s & sda_prev & ~sda_s;
  assign stop_det  = scl_s & ~sda_prev & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_busy <= 1'b0;
    else if (stop_det)  bus_busy <= 1'b0;
    else if (start_det) bus_busy <= 1'b1;
  end

  assert_stop_clears_busy_R2: assert property (
    @(posedge clk) disable iff (!rst_n) stop_det |=> !bus_busy);

  assert_start_sets_busy_R2: assert property (
    @(posedge clk) disable iff (!rst_n) start_det |=> bus_busy);

endmodule

// File: rtl/i2c_start_fsm.sv
module i2c_start_fsm
  import i2c_resv_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             bus_release,
  input  logic             arb_lost,
  input  logic             cfg_resv_off,
  input  logic             bus_busy,
  input  logic             stop_det,
  input  logic [CNT_W-1:0] hold_cnt,
  output logic             sda_drive_low,
  output logic             scl_drive_low,
  output logic             master_st,
  output logic             resv_pend
);

  mst_state_t       state;
  logic [CNT_W-1:0] hold_left;
  logic             bus_free;
  logic             launch;
  logic             reserve;

  // A stop seen in the same cycle counts as a released bus
  assign bus_free = ~bus_busy | stop_det;
  assign launch   = (state == ST_IDLE) &
                    ((start_req & bus_free) | (resv_pend & stop_det));
  assign reserve  = (state == ST_IDLE) & start_req & ~bus_free & ~cfg_resv_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hold_left <= '0;
      resv_pend <= 1'b0;
    end else if (bus_release) begin
      state     <= ST_IDLE;
      hold_left <= '0;
      resv_pend <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            state     <= ST_HOLD;
            hold_left <= hold_cnt;
            resv_pend <= 1'b0;
          end else if (reserve) begin
            resv_pend <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (arb_lost)               state     <= ST_IDLE;
          else if (hold_left == '0)   state     <= ST_WAIT;
          else                        hold_left <= hold_left - 1'b1;
        end
        ST_WAIT: begin
          if (arb_lost) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sda_drive_low = (state != ST_IDLE);
  assign scl_drive_low = (state == ST_WAIT);
  assign master_st     = (state == ST_WAIT);

  assert_hold_before_scl_R4: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(scl_drive_low) |-> $past(sda_drive_low));

  assert_resv_not_master_R5: assert property (
    @(posedge clk) disable iff (!rst_n) resv_pend |-> !sda_drive_low && !master_st);

  assert_resv_off_drops_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    cfg_resv_off && !resv_pend && !(start_req && bus_free) |=> !resv_pend);

  assert_launch_on_stop_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    resv_pend && stop_det && !bus_release |=> sda_drive_low && !resv_pend);

  assert_release_clears_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    bus_release |=> !resv_pend && !master_st && !sda_drive_low);

  assert_arb_loss_idle_R10: assert property (
    @(posedge clk) disable iff (!rst_n) arb_lost |=> !master_st && !scl_drive_low);

endmodule

// File: rtl/i2c_settle_timer.sv
module i2c_settle_timer
  import i2c_resv_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int STAT_W = CNT_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [CNT_W-1:0] lo_w,
  input  logic [CNT_W-1:0] hi_w,
  input  logic [CNT_W-1:0] fall_w,
  output logic             status_ready
);

  logic [STAT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (start_req)      remain <= STAT_W'(settle_cycles(int'(lo_w), int'(hi_w), int'(fall_w)));
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign status_ready = (remain == '0);

  assert_request_not_ready_R11: assert property (
    @(posedge clk) disable iff (!rst_n) start_req |=> !status_ready);

endmodule

// File: rtl/i2c_tx_hold.sv
module i2c_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              resv_pend,
  input  logic              tx_clr,
  output logic [DATA_W-1:0] addr_q,
  output logic              addr_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      addr_valid <= 1'b0;
    end else if (tx_clr) begin
      addr_valid <= 1'b0;
    end else if (tx_wr && !resv_pend) begin
      addr_q     <= tx_data;
      addr_valid <= 1'b1;
    end
  end

  assert_early_write_dropped_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    tx_wr && resv_pend && !tx_clr |=> $stable(addr_q) && $stable(addr_valid));

  assert_write_taken_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    tx_wr && !resv_pend && !tx_clr |=> addr_valid);

endmodule

// File: rtl/i2c_start_resv.sv
module i2c_start_resv #(
  parameter int CNT_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_in,
  input  logic              scl_in,
  input  logic              start_req,
  input  logic              bus_release,
  input  logic              arb_lost,
  input  logic              cfg_resv_off,
  input  logic              stop_irq_en,
  input  logic [CNT_W-1:0]  cfg_hi_cnt,
  input  logic [CNT_W-1:0]  cfg_lo_cnt,
  input  logic [CNT_W-1:0]  cfg_fall_cnt,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              sda_drive_low,
  output logic              scl_drive_low,
  output logic              master_st,
  output logic              resv_pend,
  output logic              bus_busy,
  output logic              stop_det,
  output logic              stop_irq,
  output logic              status_ready,
  output logic [DATA_W-1:0] addr_out,
  output logic              addr_valid
);

  localparam int STAT_W = CNT_W + 3;

  logic [1:0] line_sync;
  logic       start_det;
  logic       tx_clr;

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   ({scl_in, sda_in}),
    .sync_out (line_sync)
  );

  i2c_cond_detect u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (line_sync[0]),
    .scl_s     (line_sync[1]),
    .start_det (start_det),
    .stop_det  (stop_det),
    .bus_busy  (bus_busy)
  );

  i2c_start_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_req     (start_req),
    .bus_release   (bus_release),
    .arb_lost      (arb_lost),
    .cfg_resv_off  (cfg_resv_off),
    .bus_busy      (bus_busy),
    .stop_det      (stop_det),
    .hold_cnt      (cfg_hi_cnt),
    .sda_drive_low (sda_drive_low),
    .scl_drive_low (scl_drive_low),
    .master_st     (master_st),
    .resv_pend     (resv_pend)
  );

  i2c_settle_timer #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_settle (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .lo_w         (cfg_lo_cnt),
    .hi_w         (cfg_hi_cnt),
    .fall_w       (cfg_fall_cnt),
    .status_ready (status_ready)
  );

  assign tx_clr = bus_release | arb_lost;

  i2c_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_wr      (tx_wr),
    .tx_data    (tx_data),
    .resv_pend  (resv_pend),
    .tx_clr     (tx_clr),
    .addr_q     (addr_out),
    .addr_valid (addr_valid)
  );

  assign stop_irq = stop_det & stop_irq_en;

  assert_irq_gated_R3: assert property (
    @(posedge clk) disable iff (!rst_n) stop_irq |-> stop_irq_en && stop_det);

  assert_busy_seen_start_R2: assert property (
    @(posedge clk) disable iff (!rst_n) $rose(bus_busy) |-> $past(start_det));

endmodule

// File: tb/i2c_start_resv_bench.sv
module i2c_start_resv_bench;

  localparam int HI   = 3;
  localparam int LO   = 5;
  localparam int FALL = 2;
  localparam int SETTLE = LO + HI + 4 + 2 * FALL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_sda = 1'b1, ext_scl = 1'b1;
  logic start_req = 0, bus_release = 0, arb_lost = 0, cfg_resv_off = 0, stop_irq_en = 1;
  logic tx_wr = 0;
  logic [7:0] tx_data = '0;
  logic sda_drive_low, scl_drive_low, master_st, resv_pend, bus_busy;
  logic stop_det, stop_irq, status_ready, addr_valid;
  logic [7:0] addr_out;
  logic sda_in, scl_in;

  always #10 clk = ~clk;

  assign sda_in = ext_sda & ~sda_drive_low;
  assign scl_in = ext_scl & ~scl_drive_low;

  i2c_start_resv u_i2c_start_resv (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in),
    .start_req(start_req), .bus_release(bus_release), .arb_lost(arb_lost),
    .cfg_resv_off(cfg_resv_off), .stop_irq_en(stop_irq_en),
    .cfg_hi_cnt(8'(HI)), .cfg_lo_cnt(8'(LO)), .cfg_fall_cnt(8'(FALL)),
    .tx_wr(tx_wr), .tx_data(tx_data),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
    .master_st(master_st), .resv_pend(resv_pend), .bus_busy(bus_busy),
    .stop_det(stop_det), .stop_irq(stop_irq), .status_ready(status_ready),
    .addr_out(addr_out), .addr_valid(addr_valid)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;
  byte exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_req = 1; tick(); start_req = 0;
  endtask

  // Scoreboard monitor: S = stop detected, M = master status gained
  logic stop_q = 0, mst_q = 0;
  task automatic take(input byte ev);
    byte e;
    if (exp_q.size() == 0) begin
      chk(0, "R2/R7", "unexpected event", int'(ev), 0);
    end else begin
      e = exp_q.pop_front();
      chk(e == ev, "R2/R7", "event order", int'(ev), int'(e));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (stop_det && !stop_q) take("S");
      if (master_st && !mst_q) take("M");
    end
    stop_q = stop_det;
    mst_q  = master_st;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    // R1 reset state
    chk(!sda_drive_low && !scl_drive_low, "R1", "lines idle", sda_drive_low, 0);
    chk(!master_st && !resv_pend, "R1", "master/resv", master_st, 0);
    chk(!bus_busy && !stop_det && !addr_valid, "R1", "busy/stop/valid", bus_busy, 0);
    chk(status_ready, "R1", "status_ready", status_ready, 1);

    // R4 + R11: direct start on a free bus
    exp_q.push_back("M");
    pulse_start();
    for (int k = 0; k <= SETTLE; k++) begin
      chk(sda_drive_low, "R4", "sda held", sda_drive_low, 1);
      chk(scl_drive_low == (k >= HI + 1), "R4", "scl timing", scl_drive_low, int'(k >= HI + 1));
      chk(master_st == (k >= HI + 1), "R4", "master timing", master_st, int'(k >= HI + 1));
      chk(status_ready == (k >= SETTLE), "R11", "ready timing", status_ready, int'(k >= SETTLE));
      tick();
    end
    chk(bus_busy, "R2", "own start seen", bus_busy, 1);

    // R8 write accepted while no reservation
    tx_data = 8'hA5; tx_wr = 1; tick(); tx_wr = 0;
    chk(addr_valid && addr_out == 8'hA5, "R8", "write taken", addr_out, 'hA5);

    // R10 arbitration loss
    exp_q.push_back("S");
    arb_lost = 1; tick(); arb_lost = 0;
    chk(!master_st && !scl_drive_low && !sda_drive_low, "R10", "idle after loss", master_st, 0);
    chk(!addr_valid, "R10", "addr cleared", addr_valid, 0);
    tick(6);
    chk(!bus_busy, "R2", "busy clear after stop", bus_busy, 1'b0);

    // R5/R7/R8: reservation on a busy bus
    ext_sda = 0; tick(4);
    chk(bus_busy, "R2", "external start", bus_busy, 1);
    pulse_start();
    chk(resv_pend, "R5", "reserved", resv_pend, 1);
    chk(!sda_drive_low && !master_st, "R5", "bus untouched", sda_drive_low, 0);
    tx_data = 8'h3C; tx_wr = 1; tick(); tx_wr = 0;
    chk(!addr_valid, "R8", "early write ignored", addr_valid, 0);
    exp_q.push_back("S"); exp_q.push_back("M");
    ext_sda = 1; tick(2);
    chk(stop_det && stop_irq, "R2", "stop pulse", stop_det, 1);
    chk(resv_pend && !sda_drive_low, "R7", "waiting for stop end", resv_pend, 1);
    tick();
    chk(sda_drive_low && !resv_pend, "R7", "launched", sda_drive_low, 1);
    chk(!stop_det, "R2", "stop one cycle", stop_det, 0);
    tick(HI + 1);
    chk(master_st, "R7", "master after reservation", master_st, 1);
    tx_data = 8'h5A; tx_wr = 1; tick(); tx_wr = 0;
    chk(addr_valid && addr_out == 8'h5A, "R8", "late write taken", addr_out, 'h5A);

    // R9 release
    exp_q.push_back("S");
    bus_release = 1; tick(); bus_release = 0;
    chk(!master_st && !resv_pend && !sda_drive_low && !scl_drive_low, "R9", "released", master_st, 0);
    chk(!addr_valid, "R9", "addr cleared", addr_valid, 0);
    tick(6);

    // R6 reservation disabled
    cfg_resv_off = 1;
    ext_sda = 0; tick(4);
    pulse_start();
    chk(!resv_pend && !sda_drive_low, "R6", "request dropped", resv_pend, 0);
    exp_q.push_back("S");
    ext_sda = 1; tick(8);
    chk(!sda_drive_low && !master_st, "R6", "no start after stop", sda_drive_low, 0);
    cfg_resv_off = 0;

    // R9 release drops a pending reservation
    ext_sda = 0; tick(4);
    pulse_start();
    chk(resv_pend, "R5", "reserved again", resv_pend, 1);
    bus_release = 1; tick(); bus_release = 0;
    chk(!resv_pend, "R9", "reservation cleared", resv_pend, 0);
    exp_q.push_back("S");
    ext_sda = 1; tick(8);
    chk(!sda_drive_low && !master_st, "R9", "no launch after release", sda_drive_low, 0);

    // R3 interrupt gating
    stop_irq_en = 0;
    ext_sda = 0; tick(4);
    exp_q.push_back("S");
    ext_sda = 1; tick(2);
    chk(stop_det && !stop_irq, "R3", "irq masked", stop_irq, 0);
    tick(4);

    chk(exp_q.size() == 0, "R7", "events left", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule